// File: doc/BRIEF.md
# Vector load element address sequencer

This block turns one vectorised load of length VL into a series of memory read requests, one per active element. When a load is started it captures the base operand, the immediate offset, the operation width, the addressing mode and the predicate masks. It then walks a source element index and a destination element index upward from zero. For each element pair that is active on both sides, it presents an address on a valid/ready request port. Alongside that address it gives the destination element index, so the returned data can be written to the right place.

There are two addressing modes. In strided mode a scalar base is advanced by the operation width for every source element. In per-element-base mode the block reads a 64-bit base for source element i from a vector operand through a combinational read port (index out, data in). It adds only the immediate to that base, with no stride term. Each side has its own enable and mask, and a masked-off element on one side advances only that side's index. The load ends as soon as either index reaches VL. Data formatting, memory and register storage belong to neighbouring blocks.

Top module: `vld_addr_seq`

## Requirements
- R1: In strided mode (vec_base=0), width_sel encodes the element size in bytes as 0→1, 1→2, 2→4, 3→8. The request for source index i carries address scalar_base + i·size + imm_offs.
- R2: In per-element-base mode (vec_base=1), vbase_idx equals the current source index i. The request address is vbase_data + imm_offs, with no i·size term, whatever width_sel holds.
- R3: All address sums are taken modulo 2^64.
- R4: With both predicate enables low, the k-th accepted request has source and destination index k, and exactly VL requests are issued.
- R5: With src_pred_en=1, a source index i whose src_mask bit i is 0 issues no request. Only i advances past it.
- R6: With dst_pred_en=1, a destination index j whose dst_mask bit j is 0 issues no request. Only j advances past it; wb_idx reports j for issued requests.
- R7: Iteration ends as soon as either index reaches VL. No request carries an index at or above VL.
- R8: A request that is not accepted keeps req_valid high and its address unchanged. The indices move only on an accepted request or a skip.
- R9: done is a single-cycle pulse in the cycle after the final accepted request, or after the final skip. With VL=0 it appears in the cycle after start, and no request is issued.
- R10: A start while a load is in progress has no effect on that load.
- R11: After reset the block is idle, with req_valid, done and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load; sampled only when idle |
| vl | input | 7 | Vector length, 0 to 64 |
| vec_base | input | 1 | 1 selects per-element 64-bit bases |
| width_sel | input | 2 | Operation width code |
| scalar_base | input | 64 | Base address for strided mode |
| imm_offs | input | 64 | Immediate offset added to every address |
| src_pred_en | input | 1 | Enable source mask |
| src_mask | input | 64 | Source element mask |
| dst_pred_en | input | 1 | Enable destination mask |
| dst_mask | input | 64 | Destination element mask |
| vbase_idx | output | 6 | Element index into the base vector |
| vbase_data | input | 64 | Base vector element read back |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | 64 | Request address |
| wb_idx | output | 6 | Destination element index for this request |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load complete pulse |

## Verification
The hardest situation to reach is twin predication with masks of different density. Here the two indices drift apart and one of them reaches VL while the other still has active elements. The stimulus pairs a sparse source mask with a dense destination mask, and the reverse, so each side ends the load in turn. Stalls on the ready input are mixed into the per-element-base runs so that a held request meets a mode whose address depends on the read port.

// File: rtl/vld_addr_seq.sv
module vld_addr_seq #(
  parameter int AW    = 64,
  parameter int MAXVL = 64,
  localparam int VLW  = $clog2(MAXVL + 1),
  localparam int IW   = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic             vec_base,
  input  logic [1:0]       width_sel,
  input  logic [AW-1:0]    scalar_base,
  input  logic [AW-1:0]    imm_offs,
  input  logic             src_pred_en,
  input  logic [MAXVL-1:0] src_mask,
  input  logic             dst_pred_en,
  input  logic [MAXVL-1:0] dst_mask,
  output logic [IW-1:0]    vbase_idx,
  input  logic [AW-1:0]    vbase_data,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [AW-1:0]    req_addr,
  output logic [IW-1:0]    wb_idx,
  output logic             busy,
  output logic             done
);
  logic             busy_q, vb_q, sp_q, dp_q;
  logic [1:0]       w_q;
  logic [VLW-1:0]   vl_q, i_q, j_q;
  logic [AW-1:0]    base_q, imm_q;
  logic [MAXVL-1:0] sm_q, dm_q;

  logic fin, s_act, d_act, take;
  logic [AW-1:0] stride;

  assign fin    = (i_q >= vl_q) || (j_q >= vl_q);
  assign s_act  = !sp_q || sm_q[i_q[IW-1:0]];
  assign d_act  = !dp_q || dm_q[j_q[IW-1:0]];
  assign stride = {{(AW-VLW){1'b0}}, i_q} << w_q;

  assign busy      = busy_q;
  assign done      = busy_q && fin;
  assign req_valid = busy_q && !fin && s_act && d_act;
  assign take      = req_valid && req_ready;
  assign vbase_idx = i_q[IW-1:0];
  assign wb_idx    = j_q[IW-1:0];
  assign req_addr  = (vb_q ? vbase_data : base_q + stride) + imm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      vb_q   <= 1'b0;
      sp_q   <= 1'b0;
      dp_q   <= 1'b0;
      w_q    <= '0;
      vl_q   <= '0;
      i_q    <= '0;
      j_q    <= '0;
      base_q <= '0;
      imm_q  <= '0;
      sm_q   <= '0;
      dm_q   <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        vb_q   <= vec_base;
        sp_q   <= src_pred_en;
        dp_q   <= dst_pred_en;
        w_q    <= width_sel;
        vl_q   <= vl;
        i_q    <= '0;
        j_q    <= '0;
        base_q <= scalar_base;
        imm_q  <= imm_offs;
        sm_q   <= src_mask;
        dm_q   <= dst_mask;
      end
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (s_act && d_act) begin
      if (take) begin
        i_q <= i_q + 1'b1;
        j_q <= j_q + 1'b1;
      end
    end else begin
      if (!s_act) i_q <= i_q + 1'b1;
      if (!d_act) j_q <= j_q + 1'b1;
    end
  end
endmodule

module vld_addr_seq_chk #(
  parameter int AW = 64,
  parameter int VLW = 7,
  parameter int IW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  req_addr,
  input logic [IW-1:0]  vbase_idx,
  input logic [IW-1:0]  wb_idx,
  input logic           busy,
  input logic           done,
  input logic [VLW-1:0] vl_q
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, vbase_idx} < vl_q) && ({1'b0, wb_idx} < vl_q)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !done); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(vl_q)); // R10
  AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_valid); // R9
endmodule

bind vld_addr_seq vld_addr_seq_chk #(.AW(AW), .VLW(VLW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .vbase_idx(vbase_idx),
  .wb_idx(wb_idx), .busy(busy), .done(done), .vl_q(vl_q)
);

// File: tb/vld_addr_seq_bench.sv
module vld_addr_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic        vec_base = 1'b0;
  logic [1:0]  width_sel = '0;
  logic [63:0] scalar_base = '0, imm_offs = '0;
  logic        src_pred_en = 1'b0, dst_pred_en = 1'b0;
  logic [63:0] src_mask = '0, dst_mask = '0;
  logic [5:0]  vbase_idx, wb_idx;
  logic [63:0] vbase_data, req_addr;
  logic        req_valid, busy, done;
  logic        req_ready = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  function automatic logic [63:0] vmem(input logic [5:0] idx);
    return 64'h0000_4000_0000_0000 ^ ({58'd0, idx} * 64'h0010_0008);
  endfunction
  assign vbase_data = vmem(vbase_idx);

  vld_addr_seq u_vld_addr_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .vl(vl), .vec_base(vec_base),
    .width_sel(width_sel), .scalar_base(scalar_base), .imm_offs(imm_offs),
    .src_pred_en(src_pred_en), .src_mask(src_mask), .dst_pred_en(dst_pred_en),
    .dst_mask(dst_mask), .vbase_idx(vbase_idx), .vbase_data(vbase_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .wb_idx(wb_idx), .busy(busy), .done(done)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input int n_vl, input bit vb, input logic [1:0] w,
                          input logic [63:0] base, input logic [63:0] imm,
                          input bit sp, input logic [63:0] sm, input bit dp, input logic [63:0] dm,
                          input bit stall, input bit poke);
    logic [63:0] ea[64];
    int ei[64], ej[64];
    int n = 0, i = 0, j = 0, k = 0, dn = 0, dcyc = -1, last = -1;
    bit held = 0;
    logic [63:0] haddr = '0;
    while (i < n_vl && j < n_vl) begin
      bit sa = !sp || sm[i];
      bit da = !dp || dm[j];
      if (sa && da) begin
        ea[n] = (vb ? vmem(i[5:0]) : base + (64'(i) * (64'd1 << w))) + imm;
        ei[n] = i; ej[n] = j; n++; i++; j++;
      end else begin
        if (!sa) i++;
        if (!da) j++;
      end
    end
    @(negedge clk);
    vl = n_vl[6:0]; vec_base = vb; width_sel = w; scalar_base = base; imm_offs = imm;
    src_pred_en = sp; src_mask = sm; dst_pred_en = dp; dst_mask = dm; start = 1'b1;
    for (int cyc = 0; cyc < 400; cyc++) begin
      @(negedge clk);
      start = poke && (cyc == 2);
      if (poke && cyc == 2) begin
        vl = 7'd1; scalar_base = 64'h0; vec_base = ~vb;
      end
      req_ready = stall ? (cyc % 3 != 2) : 1'b1;
      #1;
      if (held) check({tag, " R8 hold"}, {req_valid, req_addr}, {1'b1, haddr});
      held = req_valid && !req_ready;
      haddr = req_addr;
      if (req_valid && req_ready) begin
        if (k < n) begin
          check({tag, " addr"}, req_addr, ea[k]);
          check({tag, " src idx"}, 64'(vbase_idx), 64'(ei[k]));
          check({tag, " wb idx"}, 64'(wb_idx), 64'(ej[k]));
        end
        k++; last = cyc;
      end
      if (done) begin dn++; dcyc = cyc; end
      if (dcyc >= 0 && cyc > dcyc + 3) break;
    end
    check({tag, " R7 request count"}, 64'(k), 64'(n));
    check({tag, " R9 done count"}, 64'(dn), 64'd1);
    if (n_vl == 0) check({tag, " R9 done at VL=0"}, 64'(dcyc), 64'd0);
    else if (!sp && !dp) check({tag, " R9 done timing"}, 64'(dcyc), 64'(last + 1));
    check({tag, " R11 idle after"}, {62'd0, busy, req_valid}, 64'd0);
  endtask

  task automatic t_reset;
    check("R11 reset busy", 64'(busy), 64'd0);
    check("R11 reset req_valid", 64'(req_valid), 64'd0);
    check("R11 reset done", 64'(done), 64'd0);
  endtask

  task automatic t_widths;
    for (int w = 0; w < 4; w++)
      run_case("R1 R4 stride", 6, 1'b0, w[1:0], 64'h1000, 64'h20, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic t_vector_base;
    run_case("R2 R8 vector base", 9, 1'b1, 2'd0, 64'hDEAD, 64'h8, 0, '0, 0, '0, 1, 0);
    run_case("R2 vector base w3", 5, 1'b1, 2'd3, 64'h0, 64'h100, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic t_wrap;
    run_case("R3 wrap stride", 4, 1'b0, 2'd3, 64'hFFFF_FFFF_FFFF_FFF0, 64'h20, 0, '0, 0, '0, 0, 0);
    run_case("R3 wrap vector", 3, 1'b1, 2'd1, 64'h0, 64'hFFFF_C000_0000_0000, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic t_src_pred;
    run_case("R5 src pred", 12, 1'b0, 2'd2, 64'h8000, 64'h0, 1, 64'h0000_0000_0000_0A5B, 0, '0, 1, 0);
  endtask

  task automatic t_dst_pred;
    run_case("R6 dst pred", 10, 1'b1, 2'd0, 64'h0, 64'h4, 0, '0, 1, 64'h0000_0000_0000_0366, 0, 0);
  endtask

  task automatic t_twin;
    run_case("R7 twin sparse src", 16, 1'b0, 2'd1, 64'h200, 64'h2, 1, 64'h0000_0000_0000_1111, 1, 64'h0000_0000_0000_FF7F, 1, 0);
    run_case("R7 twin sparse dst", 16, 1'b1, 2'd2, 64'h0, 64'h0, 1, 64'h0000_0000_0000_FFFB, 1, 64'h0000_0000_0000_0909, 0, 0);
    run_case("R7 all masked", 8, 1'b0, 2'd0, 64'h0, 64'h0, 1, 64'h0, 0, '0, 0, 0);
  endtask

  task automatic t_vl_zero;
    run_case("R9 vl zero", 0, 1'b0, 2'd0, 64'h40, 64'h0, 0, '0, 0, '0, 0, 0);
  endtask

  task automatic t_busy_start;
    run_case("R10 start while busy", 8, 1'b0, 2'd2, 64'h3000, 64'h10, 0, '0, 0, '0, 1, 1);
  endtask

  task automatic t_full;
    run_case("R4 full length", 64, 1'b0, 2'd3, 64'h10_0000, 64'h0, 0, '0, 0, '0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_widths();
    t_vector_base();
    t_wrap();
    t_src_pred();
    t_dst_pred();
    t_twin();
    t_vl_zero();
    t_busy_start();
    t_full();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule